// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus front end of a byte-wide flash device. Each accepted write pulse delivers an address and a data byte, and the block matches those pulses against keyed multi-cycle command sequences. It recognizes five commands: byte program, whole-chip erase, protected-region lock, identification-mode entry and identification-mode exit. When a program or erase sequence completes, the block raises a one-cycle start request to the program/erase engine. A completed lock or identification sequence updates mode state inside the block.

The block keeps a sticky protection flag for the low region of the array, from address 0 to `BOOT_LAST`. After a lock command sets the flag, no command clears it, and only a reset returns it to 0. This reset models a return to factory state. While the flag is set, the block drops program requests aimed at the low region, and it tells the engine through `erase_keep_boot` to leave that region intact during a chip erase. In identification mode the block supplies the identification bytes and the lock status on a separate read path.

Every command begins with two unlock writes: 0xAA at 0x5555, then 0x55 at 0x2AAA. The third write, at 0x5555, selects the command. The extended commands repeat the unlock pair before their final write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `prog_req` and `erase_req` are 0, `locked` is 0 and `id_mode` is 0.
- R2: The sequence 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then a fourth write A/D raises `prog_req` for exactly one cycle, in the cycle after the fourth write is accepted, with `prog_addr`=A and `prog_data`=D.
- R3: The sequence 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10 raises `erase_req` for one cycle, in the cycle after the last write. In that cycle `erase_keep_boot` equals `locked`.
- R4: The same six writes ending in 0x5555/0x40 set `locked` to 1. No later write sequence clears it, and only reset returns it to 0.
- R5: While `locked` is 1, a completed program sequence whose address is at most `BOOT_LAST` (default 0x1FFF) raises no `prog_req`. Addresses above `BOOT_LAST` are still requested.
- R6: The three-write sequence ending in 0x5555/0x90 sets `id_mode`. While `id_mode` is 1, `id_rd_data` is `MFR_CODE` (default 0x5A) at read address 0, `DEV_CODE` (default 0xC3) at address 1, and `{7'b0, locked}` at address 2. At other addresses it is 0.
- R7: The three-write sequence ending in 0x5555/0xF0 clears `id_mode`. Outside identification mode, `id_rd_data` is 0.
- R8: A write that does not match the next expected step returns the decoder to idle with no request and no mode change. A later program data write needs a fresh full unlock.
- R9: While `busy` is 1, writes are ignored and the sequence position is held, so a sequence interrupted by busy writes still completes afterwards.
- R10: After the 0x80 prefix, a second unlock pair is required. A plain address/data write right after 0x80 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also clears the lock flag |
| wr_en | input | 1 | Qualified write pulse from the bus front end |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| busy | input | 1 | Program/erase engine busy |
| id_rd_addr | input | ADDR_W | Read address for identification data |
| prog_req | output | 1 | One-cycle program start request |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | DATA_W | Program data byte |
| erase_req | output | 1 | One-cycle chip-erase start request |
| erase_keep_boot | output | 1 | Erase must preserve the protected low region |
| locked | output | 1 | Protected-region lock flag |
| id_mode | output | 1 | Identification mode active |
| id_rd_data | output | DATA_W | Identification read data |

## Verification
The bench places program addresses at `BOOT_LAST` and `BOOT_LAST`+1 once the lock is set. A design with an off-by-one boundary would either drop a legal write or let a protected byte through. It aborts sequences at the command byte and straight after the 0x80 prefix. A decoder that fails to return to idle would treat a later stray data write as a program request. It also inserts busy writes in the middle of a sequence. A design that lets busy writes abort the sequence would miss the request, and one that accepts them would advance early. Finally, it runs every command after locking and checks that the flag survives. A design that lets a command clear the flag would show `locked` dropping back to 0.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_EXT0, S_EXT1, S_EXT2
  } seq_state_t;

  typedef enum logic [2:0] {
    EV_NONE, EV_PROG, EV_ERASE, EV_LOCK, EV_ID_IN, EV_ID_OUT
  } seq_event_t;

  localparam logic [31:0] KEY_ADDR_A = 32'h5555;
  localparam logic [31:0] KEY_ADDR_B = 32'h2AAA;
  localparam logic [7:0]  KEY_UNL1   = 8'hAA;
  localparam logic [7:0]  KEY_UNL2   = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_EXT    = 8'h80;
  localparam logic [7:0]  CMD_ID_IN  = 8'h90;
  localparam logic [7:0]  CMD_ID_OUT = 8'hF0;
  localparam logic [7:0]  CMD_ERASE  = 8'h10;
  localparam logic [7:0]  CMD_LOCK   = 8'h40;

  function automatic logic key_hit(logic [31:0] a, logic [7:0] d,
                                   logic [31:0] ka, logic [7:0] kd);
    return (a == ka) && (d == kd);
  endfunction

  function automatic logic in_boot(logic [31:0] a, logic [31:0] last);
    return a <= last;
  endfunction

  function automatic logic [7:0] id_value(logic [31:0] a, logic lk,
                                          logic [7:0] mfr, logic [7:0] dev);
    case (a)
      32'd0:   return mfr;
      32'd1:   return dev;
      32'd2:   return {7'b0, lk};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output seq_event_t        ev,
  output seq_state_t        state
);
  seq_state_t state_q, state_d;
  logic [31:0] a32;

  assign a32 = 32'(wr_addr);

  always_comb begin
    state_d = state_q;
    ev      = EV_NONE;
    if (wr_accept) begin
      state_d = S_IDLE;
      case (state_q)
        S_IDLE: if (key_hit(a32, wr_data, KEY_ADDR_A, KEY_UNL1)) state_d = S_UNL1;
        S_UNL1: if (key_hit(a32, wr_data, KEY_ADDR_B, KEY_UNL2)) state_d = S_UNL2;
        S_UNL2: begin
          if (key_hit(a32, wr_data, KEY_ADDR_A, CMD_PROG))        state_d = S_PROG;
          else if (key_hit(a32, wr_data, KEY_ADDR_A, CMD_EXT))    state_d = S_EXT0;
          else if (key_hit(a32, wr_data, KEY_ADDR_A, CMD_ID_IN))  ev = EV_ID_IN;
          else if (key_hit(a32, wr_data, KEY_ADDR_A, CMD_ID_OUT)) ev = EV_ID_OUT;
        end
        S_PROG: ev = EV_PROG;
        S_EXT0: if (key_hit(a32, wr_data, KEY_ADDR_A, KEY_UNL1)) state_d = S_EXT1;
        S_EXT1: if (key_hit(a32, wr_data, KEY_ADDR_B, KEY_UNL2)) state_d = S_EXT2;
        S_EXT2: begin
          if (key_hit(a32, wr_data, KEY_ADDR_A, CMD_ERASE))     ev = EV_ERASE;
          else if (key_hit(a32, wr_data, KEY_ADDR_A, CMD_LOCK)) ev = EV_LOCK;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R9: with no accepted write the sequence position does not move
  a_r9_hold_when_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> state_q == $past(state_q));

  // R2: the data write of a program is only reached through the command step
  a_r2_prog_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PROG) && (state_q != $past(state_q)) |-> $past(state_q) == S_UNL2);

endmodule

// File: rtl/fcd_mode_regs.sv
module fcd_mode_regs
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [7:0]  MFR_CODE = 8'h5A,
  parameter logic [7:0]  DEV_CODE = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_event_t        ev,
  input  logic [ADDR_W-1:0] id_rd_addr,
  output logic              locked,
  output logic              id_mode,
  output logic [7:0]        id_rd_data
);
  logic locked_q, id_mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q  <= 1'b0;
      id_mode_q <= 1'b0;
    end else begin
      if (ev == EV_LOCK)   locked_q  <= 1'b1;
      if (ev == EV_ID_IN)  id_mode_q <= 1'b1;
      if (ev == EV_ID_OUT) id_mode_q <= 1'b0;
    end
  end

  assign locked     = locked_q;
  assign id_mode    = id_mode_q;
  assign id_rd_data = id_mode_q ? id_value(32'(id_rd_addr), locked_q, MFR_CODE, DEV_CODE)
                                : 8'h00;

  // R4: the lock flag never falls outside reset
  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);

  // R7: identification mode only leaves on the exit event
  a_r7_id_exit_only: assert property (@(posedge clk) disable iff (!rst_n)
    id_mode_q && (ev != EV_ID_OUT) |=> id_mode_q);

endmodule

// File: rtl/fcd_issue.sv
module fcd_issue
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [31:0] BOOT_LAST = 32'h1FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_event_t        ev,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              locked,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_req,
  output logic              erase_keep_boot
);
  logic prog_ok;

  assign prog_ok = (ev == EV_PROG) && !(locked && in_boot(32'(wr_addr), BOOT_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_req        <= 1'b0;
      prog_addr       <= '0;
      prog_data       <= '0;
      erase_req       <= 1'b0;
      erase_keep_boot <= 1'b0;
    end else begin
      prog_req  <= prog_ok;
      erase_req <= (ev == EV_ERASE);
      if (prog_ok) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (ev == EV_ERASE) erase_keep_boot <= locked;
    end
  end

  // R5: no request ever targets the protected range while locked
  a_r5_boot_guard: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req && locked |-> !in_boot(32'(prog_addr), BOOT_LAST));

  // R3: erase carries the lock state seen by the engine
  a_r3_keep_matches: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> erase_keep_boot == locked);

  // R2: requests last a single cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [31:0] BOOT_LAST = 32'h1FFF,
  parameter logic [7:0]  MFR_CODE  = 8'h5A,
  parameter logic [7:0]  DEV_CODE  = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] id_rd_addr,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_req,
  output logic              erase_keep_boot,
  output logic              locked,
  output logic              id_mode,
  output logic [DATA_W-1:0] id_rd_data
);
  localparam int KEY_W = 8;

  logic       wr_accept;
  seq_event_t seq_ev;
  seq_state_t seq_state;
  logic [KEY_W-1:0] key_byte;
  logic [7:0]       id_byte;

  assign wr_accept = wr_en && !busy;
  assign key_byte  = wr_data[KEY_W-1:0];

  fcd_seq_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept),
    .wr_addr(wr_addr), .wr_data(key_byte), .ev(seq_ev), .state(seq_state)
  );

  fcd_mode_regs #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) i_mode (
    .clk(clk), .rst_n(rst_n), .ev(seq_ev), .id_rd_addr(id_rd_addr),
    .locked(locked), .id_mode(id_mode), .id_rd_data(id_byte)
  );

  assign id_rd_data = DATA_W'(id_byte);

  fcd_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_LAST(BOOT_LAST)) i_issue (
    .clk(clk), .rst_n(rst_n), .ev(seq_ev), .wr_addr(wr_addr), .wr_data(wr_data),
    .locked(locked), .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_req(erase_req), .erase_keep_boot(erase_keep_boot)
  );

  // R9: a write during busy never produces a request
  a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy |=> !prog_req && !erase_req);

  // R8: requests only follow an accepted write
  a_r8_req_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || erase_req) |-> $past(wr_accept));

  // R2: at most one kind of request at a time
  a_r2_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, erase_req}));

  // R10: the extended prefix state is left only toward idle or the second unlock
  a_r10_ext_path: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == S_EXT0) && wr_accept |=> (seq_state == S_IDLE) || (seq_state == S_EXT1));

endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  logic        clk = 0, rst_n = 0, wr_en = 0, busy = 0;
  logic [15:0] wr_addr = 0, id_rd_addr = 0, prog_addr;
  logic [7:0]  wr_data = 0, prog_data, id_rd_data;
  logic        prog_req, erase_req, erase_keep_boot, locked, id_mode;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .id_rd_addr(id_rd_addr), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_req(erase_req), .erase_keep_boot(erase_keep_boot),
    .locked(locked), .id_mode(id_mode), .id_rd_data(id_rd_data)
  );

  function automatic bit exp_prog(logic [15:0] a, bit lk);
    return !(lk && (a < 16'h2000));
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, bit b = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; busy = b;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; busy = 0;
  endtask

  task automatic cmd3(logic [7:0] c);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, c);
  endtask

  task automatic ext6(logic [7:0] c);
    cmd3(8'h80); cmd3(c);
  endtask

  task automatic do_prog(logic [15:0] a, logic [7:0] d, bit lk, string req);
    cmd3(8'hA0); wr(a, d);
    check(req, prog_req, exp_prog(a, lk));
    if (exp_prog(a, lk)) begin
      check(req, prog_addr, a);
      check(req, prog_data, d);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 prog_req", prog_req, 0);
    check("R1 erase_req", erase_req, 0);
    check("R1 locked", locked, 0);
    check("R1 id_mode", id_mode, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 basic program and single-cycle pulse
    do_prog(16'h4321, 8'h3C, 0, "R2 program");
    @(negedge clk);
    check("R2 pulse ends", prog_req, 0);
    do_prog(16'h0100, 8'h00, 0, "R5 boot unlocked");

    // R3 erase while unlocked
    ext6(8'h10);
    check("R3 erase_req", erase_req, 1);
    check("R3 keep_boot", erase_keep_boot, 0);

    // R8 abort at command byte, then stray data write
    cmd3(8'h77);
    wr(16'h3000, 8'h12);
    check("R8 no req after abort", prog_req, 0);
    // R8 abort at second unlock
    wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55); wr(16'h5555, 8'hA0); wr(16'h3000, 8'h12);
    check("R8 bad unlock", prog_req, 0);

    // R10 prefix then plain write
    cmd3(8'h80);
    wr(16'h3000, 8'h12);
    check("R10 prog_req", prog_req, 0);
    check("R10 erase_req", erase_req, 0);
    check("R10 locked", locked, 0);

    // R9 busy writes in the middle are ignored
    wr(16'h5555, 8'hAA);
    wr(16'h1234, 8'h99, 1);
    wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
    wr(16'h6000, 8'h81, 1);
    check("R9 busy final write", prog_req, 0);
    wr(16'h6001, 8'h82);
    check("R9 resumed", prog_req, 1);
    check("R9 addr", prog_addr, 16'h6001);

    // R6 identification mode before lock
    cmd3(8'h90);
    check("R6 id_mode", id_mode, 1);
    id_rd_addr = 0; #1 check("R6 mfr", id_rd_data, 8'h5A);
    id_rd_addr = 1; #1 check("R6 dev", id_rd_data, 8'hC3);
    id_rd_addr = 2; #1 check("R6 lock bit", id_rd_data, 0);
    id_rd_addr = 7; #1 check("R6 other", id_rd_data, 0);

    // R4 lock
    ext6(8'h40);
    check("R4 locked", locked, 1);
    check("R4 no erase", erase_req, 0);
    id_rd_addr = 2; #1 check("R6 lock bit set", id_rd_data, 1);
    cmd3(8'hF0);
    check("R7 id exit", id_mode, 0);
    #1 check("R7 id data zero", id_rd_data, 0);

    // R5 boundary while locked
    do_prog(16'h1FFF, 8'h11, 1, "R5 last boot byte");
    do_prog(16'h2000, 8'h22, 1, "R5 first main byte");
    do_prog(16'h0000, 8'h33, 1, "R5 first boot byte");
    ext6(8'h10);
    check("R3 erase locked", erase_req, 1);
    check("R3 keep_boot locked", erase_keep_boot, 1);

    // R4 every command after lock leaves it set
    cmd3(8'h90); cmd3(8'hF0); ext6(8'h10); ext6(8'h40); cmd3(8'h80); cmd3(8'h00);
    check("R4 still locked", locked, 1);

    // random programs with aborts and busy writes (R2 R5 R8 R9)
    void'($urandom(32'h1D2E));
    for (int i = 0; i < 60; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int k;
      a = 16'($urandom); d = 8'($urandom); k = $urandom_range(0, 3);
      if (k == 0) begin
        cmd3(8'($urandom_range(0, 15)));
        wr(a, d);
        check("R8 random abort", prog_req, 0);
      end else begin
        wr(16'h5555, 8'hAA);
        if (k == 1) wr(16'h5555, 8'hAA, 1);
        wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
        wr(a, d);
        check("R5 random req", prog_req, exp_prog(a, 1));
        if (exp_prog(a, 1)) check("R2 random data", prog_data, d);
      end
    end

    // R1 reset returns lock to 0
    rst_n = 0;
    @(negedge clk);
    check("R1 lock cleared by reset", locked, 0);
    rst_n = 1;
    @(negedge clk);
    do_prog(16'h0800, 8'h5E, 0, "R5 boot after reset");

    finish_run();
  end
endmodule